// File: doc/BRIEF.md
# Wakeup Memory Integrity Boot Sequencer

This block decides whether a companion core may start running after the chip leaves its low-power standby state. While the chip sleeps, the core's firmware image sits in a retained memory. On the way out of standby, the block checks that memory in two stages, and the core only runs if both pass.

The first stage reads every image word through a per-word SECDED code. It corrects and writes back single-bit upsets. It stops on the first uncorrectable word. The second stage runs a CRC-32 over the corrected image and compares the result with a reference CRC that the main processor supplied together with the image. On success the core's reset is released and it boots from the base of the retained memory. On failure, a configuration bit selects the response: a sticky error interrupt to the main processor, or a one-cycle request for a full system reset. A sticky status records which stage failed and at which word.

The retained memory is modelled inside the block as a synchronous RAM. It has a write port for the main processor and a codeword upset mask so that retention faults can be injected. Its depth is a parameter. The product configuration uses 32768 words (128 KB); the default is kept small for elaboration.

Top module: `wkup_integrity_boot`

## Requirements
- R1: A check sequence starts only when `standby_exit` and `wkup_cc` are both high in the same cycle while the block is idle. Any other wakeup leaves `cc_rst_n` low and the status unchanged.
- R2: The ECC stage scans words 0 to N-1, where N = `cfg_img_len`/4. The CRC stage starts only after every word has passed ECC.
- R3: The CRC is CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. It takes one word per clock, bit 31 first, and is compared with `cfg_ref_crc`.
- R4: On success, `cc_rst_n` goes high and `cc_boot_addr` equals the `BASE_ADDR` parameter (default 0x0000_0000). Each new sequence drives `cc_rst_n` low again.
- R5: On failure with `cfg_fail_rst`=0, `err_irq` is set and stays high until `stat_clr`. With `cfg_fail_rst`=1, `sys_rst_req` pulses for exactly one cycle and `err_irq` stays low.
- R6: A word with an uncorrectable (two-bit) error aborts the scan. The status shows stage code 1 (ECC) and the word index in `stat_addr`, and the CRC stage never runs.
- R7: A word with a single-bit error is corrected, written back and counted in `corr_cnt` (saturating), and the scan continues. A later sequence over the same memory counts no errors.
- R8: A CRC mismatch gives stage code 2 (CRC), with `stat_addr` = N-1.
- R9: An image length that is zero, not a multiple of 4, or larger than the memory goes straight to failure with stage code 3 (length) and `stat_addr` 0.
- R10: `stat_stage`, `stat_addr` and `corr_cnt` keep their values until `stat_clr`. `stat_clr` clears them and `err_irq`. Stage code 0 means no failure.
- R11: Start requests that arrive while a sequence is running are ignored.
- R12: Host writes to the retained memory are ignored while a sequence is running.
- R13: After reset, `cc_rst_n`, `err_irq` and `sys_rst_req` are low and `stat_stage` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_exit | input | 1 | Pulse marking exit from standby |
| wkup_cc | input | 1 | Wakeup event is assigned to the companion core |
| cfg_img_len | input | AW+3 | Image length in bytes |
| cfg_ref_crc | input | 32 | Reference CRC of the image |
| cfg_fail_rst | input | 1 | Failure response: 0 error interrupt, 1 system reset request |
| host_we | input | 1 | Host write strobe into retained memory |
| host_addr | input | AW | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_flip | input | 39 | XOR mask applied to the stored codeword (upset injection) |
| stat_clr | input | 1 | Clears status, correction count and error interrupt |
| cc_rst_n | output | 1 | Companion core reset, active low |
| cc_boot_addr | output | 32 | Companion core start address |
| err_irq | output | 1 | Sticky error interrupt to the main processor |
| sys_rst_req | output | 1 | One-cycle system reset request |
| stat_stage | output | 2 | Failing stage: 0 none, 1 ECC, 2 CRC, 3 length |
| stat_addr | output | AW | Word index of the failure |
| corr_cnt | output | CNT_W | Count of corrected single-bit words |

## Verification
The hardest situations to reach are the ones that touch the retained array: a correctable upset that must be written back during the scan, and an uncorrectable upset in a word whose CRC would also be wrong. The stimulus reaches both through the host port's codeword XOR mask, which flips one or two random codeword bits in chosen words before the wakeup. The scrub write-back is then checked by running a second sequence and seeing zero corrections. Random rounds mix image lengths, upset positions, fail modes and corrupted reference CRCs; directed cases cover length 1, the full memory, bad lengths, and requests and writes that arrive mid-scan.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  localparam int DW   = 32;
  localparam int PB   = 6;           // Hamming check bits
  localparam int CW   = DW + PB + 1; // plus overall parity at bit 0

  typedef enum logic [2:0] {
    ST_IDLE, ST_ECC, ST_CRC, ST_CMP, ST_REL, ST_FAIL
  } wbs_state_e;

  typedef enum logic [1:0] {
    FS_NONE = 2'd0, FS_ECC = 2'd1, FS_CRC = 2'd2, FS_LEN = 2'd3
  } wbs_fstage_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          sbe;
    logic          dbe;
  } wbs_dec_t;

  function automatic logic [CW-1:0] secded_enc(input logic [DW-1:0] d);
    logic [CW-1:0] cw;
    logic          par;
    int            j;
    cw = '0;
    j  = 0;
    for (int k = 1; k < CW; k++) begin
      if ((k & (k - 1)) != 0) begin
        cw[k] = d[j];
        j++;
      end
    end
    for (int p = 0; p < PB; p++) begin
      par = 1'b0;
      for (int k = 1; k < CW; k++)
        if (((k >> p) & 1) == 1) par = par ^ cw[k];
      cw[1 << p] = par;
    end
    cw[0] = ^cw[CW-1:1];
    return cw;
  endfunction

  function automatic wbs_dec_t secded_dec(input logic [CW-1:0] cw);
    wbs_dec_t      r;
    logic [PB-1:0] syn;
    logic [CW-1:0] fx;
    logic          ov;
    int            j;
    syn = '0;
    for (int p = 0; p < PB; p++)
      for (int k = 1; k < CW; k++)
        if (((k >> p) & 1) == 1) syn[p] = syn[p] ^ cw[k];
    ov    = ^cw;
    fx    = cw;
    r.sbe = 1'b0;
    r.dbe = 1'b0;
    if (ov) begin
      if (int'(syn) < CW) begin
        fx[syn] = ~fx[syn];
        r.sbe   = 1'b1;
      end else begin
        r.dbe = 1'b1;
      end
    end else if (syn != '0) begin
      r.dbe = 1'b1;
    end
    r.data = '0;
    j = 0;
    for (int k = 1; k < CW; k++) begin
      if ((k & (k - 1)) != 0) begin
        r.data[j] = fx[k];
        j++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/wbs_ecc_ram.sv
`timescale 1ns/1ps
module wbs_ecc_ram
  import wbs_pkg::*;
#(
  parameter int WORDS = 1024,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] wflip,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rcw
);
  logic [CW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= secded_enc(wdata) ^ wflip;
    if (re) rcw <= mem[raddr];
  end
endmodule

// File: rtl/wbs_secded_dec.sv
`timescale 1ns/1ps
module wbs_secded_dec
  import wbs_pkg::*;
(
  input  logic [CW-1:0] cw,
  output logic [DW-1:0] data,
  output logic          sbe,
  output logic          dbe
);
  wbs_dec_t res;
  always_comb res = secded_dec(cw);
  assign data = res.data;
  assign sbe  = res.sbe;
  assign dbe  = res.dbe;
endmodule

// File: rtl/wbs_crc32.sv
`timescale 1ns/1ps
module wbs_crc32 #(
  parameter logic [31:0] POLY   = 32'h04C1_1DB7,
  parameter logic [31:0] INIT   = 32'hFFFF_FFFF,
  parameter logic [31:0] XOROUT = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [31:0] word,
  output logic [31:0] crc
);
  logic [31:0] crc_q, crc_d;

  function automatic logic [31:0] step(input logic [31:0] c0, input logic [31:0] w);
    logic [31:0] c;
    logic        fb;
    c = c0;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ w[i];
      c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    return c;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = INIT;
    else if (en) crc_d = step(crc_q, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= INIT;
    else if (clr || en)  crc_q <= crc_d;
  end

  assign crc = crc_q ^ XOROUT;
endmodule

// File: rtl/wbs_ctrl.sv
`timescale 1ns/1ps
module wbs_ctrl
  import wbs_pkg::*;
#(
  parameter int WORDS  = 1024,
  parameter int CNT_W  = 8,
  localparam int AW    = $clog2(WORDS),
  localparam int LEN_W = AW + 3,
  localparam int NW_W  = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_exit,
  input  logic             wkup_cc,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [31:0]      cfg_ref_crc,
  input  logic             cfg_fail_rst,
  input  logic             stat_clr,
  input  logic [DW-1:0]    dec_data,
  input  logic             dec_sbe,
  input  logic             dec_dbe,
  input  logic [31:0]      crc_val,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             scrub_we,
  output logic [AW-1:0]    scrub_addr,
  output logic [DW-1:0]    scrub_data,
  output logic             crc_clr,
  output logic             crc_en,
  output logic [31:0]      crc_word,
  output logic             busy,
  output logic             cc_rel,
  output logic             err_irq,
  output logic             sys_rst_req,
  output logic [1:0]       stat_stage,
  output logic [AW-1:0]    stat_addr,
  output logic [CNT_W-1:0] corr_cnt
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(WORDS * 4);

  wbs_state_e       state_q, state_d;
  logic [NW_W-1:0]  ptr_q, ptr_d, nw_q, nw_d;
  logic             vld_q, vld_d;
  logic [AW-1:0]    vaddr_q, vaddr_d;
  logic             rel_q, rel_d, irq_q, irq_d, srst_q, srst_d;
  wbs_fstage_e      stage_q, stage_d;
  logic [AW-1:0]    faddr_q, faddr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic            len_ok, issue, last, start;
  logic [NW_W-1:0] len_words;

  assign len_words = cfg_len[LEN_W-1:2];
  assign len_ok    = (cfg_len != '0) && (cfg_len[1:0] == 2'b00) && (cfg_len <= MAX_LEN);
  assign issue     = (ptr_q < nw_q);
  assign last      = vld_q && ({1'b0, vaddr_q} == (nw_q - NW_W'(1)));
  assign start     = (state_q == ST_IDLE) && standby_exit && wkup_cc;

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    vld_d    = 1'b0;
    vaddr_d  = ptr_q[AW-1:0];
    nw_d     = nw_q;
    rel_d    = rel_q;
    irq_d    = irq_q;
    srst_d   = 1'b0;
    stage_d  = stage_q;
    faddr_d  = faddr_q;
    cnt_d    = cnt_q;
    rd_en    = 1'b0;
    scrub_we = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    if (stat_clr) begin
      stage_d = FS_NONE;
      faddr_d = '0;
      cnt_d   = '0;
      irq_d   = 1'b0;
    end
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          rel_d   = 1'b0;
          crc_clr = 1'b1;
          ptr_d   = '0;
          nw_d    = len_words;
          if (len_ok) begin
            state_d = ST_ECC;
          end else begin
            state_d = ST_FAIL;
            stage_d = FS_LEN;
            faddr_d = '0;
          end
        end
      end
      ST_ECC: begin
        if (issue) begin
          rd_en = 1'b1;
          ptr_d = ptr_q + NW_W'(1);
          vld_d = 1'b1;
        end
        if (vld_q) begin
          if (dec_dbe) begin
            state_d = ST_FAIL;
            stage_d = FS_ECC;
            faddr_d = vaddr_q;
          end else begin
            if (dec_sbe) begin
              scrub_we = 1'b1;
              if (cnt_d != '1) cnt_d = cnt_d + CNT_W'(1);
            end
            if (last) begin
              state_d = ST_CRC;
              ptr_d   = '0;
              vld_d   = 1'b0;
            end
          end
        end
      end
      ST_CRC: begin
        if (issue) begin
          rd_en = 1'b1;
          ptr_d = ptr_q + NW_W'(1);
          vld_d = 1'b1;
        end
        if (vld_q) begin
          if (dec_dbe) begin
            state_d = ST_FAIL;
            stage_d = FS_ECC;
            faddr_d = vaddr_q;
          end else begin
            crc_en = 1'b1;
            if (last) state_d = ST_CMP;
          end
        end
      end
      ST_CMP: begin
        if (crc_val == cfg_ref_crc) begin
          state_d = ST_REL;
        end else begin
          state_d = ST_FAIL;
          stage_d = FS_CRC;
          faddr_d = AW'(nw_q - NW_W'(1));
        end
      end
      ST_REL: begin
        rel_d   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FAIL: begin
        if (cfg_fail_rst) srst_d = 1'b1;
        else              irq_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      vld_q   <= 1'b0;
      vaddr_q <= '0;
      nw_q    <= '0;
      rel_q   <= 1'b0;
      irq_q   <= 1'b0;
      srst_q  <= 1'b0;
      stage_q <= FS_NONE;
      faddr_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      rel_q   <= rel_d;
      irq_q   <= irq_d;
      srst_q  <= srst_d;
      stage_q <= stage_d;
      faddr_q <= faddr_d;
      cnt_q   <= cnt_d;
      if (state_q != ST_IDLE || start) ptr_q <= ptr_d;
      if (vld_d)                       vaddr_q <= vaddr_d;
      if (start)                       nw_q <= nw_d;
    end
  end

  assign rd_addr     = ptr_q[AW-1:0];
  assign scrub_addr  = vaddr_q;
  assign scrub_data  = dec_data;
  assign crc_word    = dec_data;
  assign busy        = (state_q != ST_IDLE);
  assign cc_rel      = rel_q;
  assign err_irq     = irq_q;
  assign sys_rst_req = srst_q;
  assign stat_stage  = stage_q;
  assign stat_addr   = faddr_q;
  assign corr_cnt    = cnt_q;

  // R4: the core is only released out of the release state
  a_r4_release_from_rel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(state_q) == ST_REL);

  // R2: the CRC stage is only entered from the ECC stage
  a_r2_crc_after_ecc: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC && $past(state_q) != ST_CRC) |-> $past(state_q) == ST_ECC);

  // R6: an uncorrectable word aborts the ECC scan
  a_r6_dbe_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ECC && vld_q && dec_dbe) |=> (state_q == ST_FAIL && stage_q == FS_ECC));

  // R5: the reset request is a single-cycle pulse
  a_r5_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  // R10: the interrupt holds until cleared
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !stat_clr) |=> irq_q);

  // R11: a running sequence never restarts its ECC scan
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC || state_q == ST_CMP) |=> state_q != ST_ECC);

  // R7: the correction count never decreases without a clear
  a_r7_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/wkup_integrity_boot.sv
`timescale 1ns/1ps
module wkup_integrity_boot
  import wbs_pkg::*;
#(
  parameter int          WORDS     = 1024,
  parameter int          CNT_W     = 8,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0000,
  localparam int         AW        = $clog2(WORDS),
  localparam int         LEN_W     = AW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_exit,
  input  logic             wkup_cc,
  input  logic [LEN_W-1:0] cfg_img_len,
  input  logic [31:0]      cfg_ref_crc,
  input  logic             cfg_fail_rst,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [31:0]      host_wdata,
  input  logic [CW-1:0]    host_flip,
  input  logic             stat_clr,
  output logic             cc_rst_n,
  output logic [31:0]      cc_boot_addr,
  output logic             err_irq,
  output logic             sys_rst_req,
  output logic [1:0]       stat_stage,
  output logic [AW-1:0]    stat_addr,
  output logic [CNT_W-1:0] corr_cnt
);
  logic          rd_en, scrub_we, crc_clr, crc_en, busy, cc_rel;
  logic [AW-1:0] rd_addr, scrub_addr, ram_waddr;
  logic [DW-1:0] scrub_data, dec_data, crc_word, ram_wdata;
  logic [CW-1:0] rcw, ram_wflip;
  logic          dec_sbe, dec_dbe, ram_we, host_ok;
  logic [31:0]   crc_val;

  assign host_ok   = host_we && !busy;
  assign ram_we    = scrub_we || host_ok;
  assign ram_waddr = scrub_we ? scrub_addr : host_addr;
  assign ram_wdata = scrub_we ? scrub_data : host_wdata;
  assign ram_wflip = scrub_we ? '0 : host_flip;

  wbs_ecc_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .wflip(ram_wflip), .re(rd_en), .raddr(rd_addr), .rcw(rcw)
  );

  wbs_secded_dec u_dec (
    .cw(rcw), .data(dec_data), .sbe(dec_sbe), .dbe(dec_dbe)
  );

  wbs_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .word(crc_word), .crc(crc_val)
  );

  wbs_ctrl #(.WORDS(WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit), .wkup_cc(wkup_cc),
    .cfg_len(cfg_img_len), .cfg_ref_crc(cfg_ref_crc), .cfg_fail_rst(cfg_fail_rst),
    .stat_clr(stat_clr), .dec_data(dec_data), .dec_sbe(dec_sbe), .dec_dbe(dec_dbe),
    .crc_val(crc_val), .rd_en(rd_en), .rd_addr(rd_addr), .scrub_we(scrub_we),
    .scrub_addr(scrub_addr), .scrub_data(scrub_data), .crc_clr(crc_clr),
    .crc_en(crc_en), .crc_word(crc_word), .busy(busy), .cc_rel(cc_rel),
    .err_irq(err_irq), .sys_rst_req(sys_rst_req), .stat_stage(stat_stage),
    .stat_addr(stat_addr), .corr_cnt(corr_cnt)
  );

  assign cc_rst_n     = cc_rel;
  assign cc_boot_addr = BASE_ADDR;

  // R12: while busy, only scrub write-backs reach the array
  a_r12_no_host_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && busy) |-> scrub_we);

  // R4: a released core stays released until a new sequence starts
  a_r4_rel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_rst_n && !busy && !(standby_exit && wkup_cc)) |=> cc_rst_n);
endmodule

// File: tb/tb_wkup_integrity_boot.sv
`timescale 1ns/1ps
module tb_wkup_integrity_boot;
  localparam int WORDS = 1024;
  localparam int AW    = $clog2(WORDS);
  localparam int LEN_W = AW + 3;
  localparam int CW    = 39;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             standby_exit, wkup_cc, cfg_fail_rst, host_we, stat_clr;
  logic [LEN_W-1:0] cfg_img_len;
  logic [31:0]      cfg_ref_crc, host_wdata;
  logic [AW-1:0]    host_addr;
  logic [CW-1:0]    host_flip;
  logic             cc_rst_n, err_irq, sys_rst_req;
  logic [31:0]      cc_boot_addr;
  logic [1:0]       stat_stage;
  logic [AW-1:0]    stat_addr;
  logic [CNT_W-1:0] corr_cnt;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] img [WORDS];
  int outcome;  // 0 timeout, 1 release, 2 irq, 3 system reset
  bit  srst_seen_next;

  always #2 clk = ~clk;  // 250 MHz

  wkup_integrity_boot #(.WORDS(WORDS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit), .wkup_cc(wkup_cc),
    .cfg_img_len(cfg_img_len), .cfg_ref_crc(cfg_ref_crc), .cfg_fail_rst(cfg_fail_rst),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_flip(host_flip), .stat_clr(stat_clr), .cc_rst_n(cc_rst_n),
    .cc_boot_addr(cc_boot_addr), .err_irq(err_irq), .sys_rst_req(sys_rst_req),
    .stat_stage(stat_stage), .stat_addr(stat_addr), .corr_cnt(corr_cnt)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc(input int n);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int w = 0; w < n; w++)
      for (int b = 31; b >= 0; b--) begin
        fb = c[31] ^ img[w][b];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return ~c;
  endfunction

  task automatic host_write(input int a, input logic [31:0] d, input logic [CW-1:0] f);
    host_we = 1'b1; host_addr = AW'(a); host_wdata = d; host_flip = f;
    @(negedge clk);
    host_we = 1'b0; host_flip = '0;
  endtask

  task automatic load_image(input int n);
    for (int i = 0; i < n; i++) begin
      img[i] = $urandom;
      host_write(i, img[i], '0);
    end
  endtask

  task automatic clear_status();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic wake(input logic assigned);
    standby_exit = 1'b1; wkup_cc = assigned;
    @(negedge clk);
    standby_exit = 1'b0; wkup_cc = 1'b0;
  endtask

  task automatic wait_done();
    outcome = 0;
    srst_seen_next = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (cc_rst_n)    begin outcome = 1; break; end
      if (err_irq)     begin outcome = 2; break; end
      if (sys_rst_req) begin outcome = 3; break; end
      @(negedge clk);
    end
    if (outcome == 3) begin
      @(negedge clk);
      srst_seen_next = sys_rst_req;
    end
  endtask

  task automatic run_seq(input int len_bytes, input logic [31:0] ref_crc, input logic mode);
    cfg_img_len = LEN_W'(len_bytes); cfg_ref_crc = ref_crc; cfg_fail_rst = mode;
    wake(1'b1);
    wait_done();
  endtask

  function automatic logic [CW-1:0] one_bit(input int b);
    return CW'(1) << b;
  endfunction

  initial begin
    logic [31:0] c;
    int n, k, b1, b2, w1, w2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; standby_exit = 1'b0; wkup_cc = 1'b0; cfg_fail_rst = 1'b0;
    host_we = 1'b0; stat_clr = 1'b0; cfg_img_len = '0; cfg_ref_crc = '0;
    host_addr = '0; host_wdata = '0; host_flip = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check(!cc_rst_n && !err_irq && !sys_rst_req, "R13 reset outputs",
          {29'd0, cc_rst_n, err_irq, sys_rst_req}, 32'd0);
    check(stat_stage == 2'd0, "R13 stage after reset", 32'(stat_stage), 32'd0);
    check(cc_boot_addr == 32'h0, "R4 boot address", cc_boot_addr, 32'h0);

    // R1: wakeups not for the core, and assignment without standby exit
    n = 16;
    load_image(n);
    cfg_img_len = LEN_W'(n * 4); cfg_ref_crc = model_crc(n); cfg_fail_rst = 1'b0;
    wake(1'b0);
    wkup_cc = 1'b1;
    repeat (100) @(negedge clk);
    wkup_cc = 1'b0;
    check(!cc_rst_n && !err_irq, "R1 core held on foreign wakeup",
          {30'd0, cc_rst_n, err_irq}, 32'd0);
    check(stat_stage == 2'd0, "R1 status untouched", 32'(stat_stage), 32'd0);

    // R2 R3 R4 basic release
    run_seq(n * 4, model_crc(n), 1'b0);
    check(outcome == 1, "R3 release on matching CRC", 32'(outcome), 32'd1);
    check(stat_stage == 2'd0 && corr_cnt == 0, "R2 clean scan status",
          {22'd0, stat_stage, corr_cnt}, 32'd0);

    // R9 invalid lengths
    clear_status();
    run_seq(0, 32'h0, 1'b0);
    check(outcome == 2 && stat_stage == 2'd3, "R9 zero length",
          {28'd0, 2'(outcome), stat_stage}, {28'd0, 2'd2, 2'd3});
    check(!cc_rst_n, "R4 new sequence re-holds core", 32'(cc_rst_n), 32'd0);
    clear_status();
    run_seq(6, 32'h0, 1'b0);
    check(outcome == 2 && stat_stage == 2'd3 && stat_addr == 0, "R9 misaligned length",
          {22'd0, stat_stage, stat_addr}, {22'd0, 2'd3, 10'd0});
    clear_status();
    run_seq(WORDS * 4 + 4, 32'h0, 1'b0);
    check(outcome == 2 && stat_stage == 2'd3, "R9 oversize length",
          32'(stat_stage), 32'd3);

    // R10 status sticky, then cleared
    repeat (20) @(negedge clk);
    check(err_irq && stat_stage == 2'd3, "R10 status sticky", 32'(stat_stage), 32'd3);
    clear_status();
    check(!err_irq && stat_stage == 2'd0, "R10 clear", {29'd0, err_irq, stat_stage}, 32'd0);

    // R6: double error at word 5 with a wrong reference too; system reset mode
    n = 20;
    load_image(n);
    host_write(5, img[5], one_bit(3) | one_bit(17));
    run_seq(n * 4, ~model_crc(n), 1'b1);
    check(outcome == 3, "R5 reset request on failure", 32'(outcome), 32'd3);
    check(!srst_seen_next, "R5 reset request one cycle", 32'(srst_seen_next), 32'd0);
    check(!err_irq, "R5 no interrupt in reset mode", 32'(err_irq), 32'd0);
    check(stat_stage == 2'd1 && stat_addr == 5, "R6 ECC abort status",
          {22'd0, stat_stage, stat_addr}, {22'd0, 2'd1, 10'd5});
    host_write(5, img[5], '0);
    clear_status();

    // R7: single flips corrected, counted and scrubbed
    host_write(2, img[2], one_bit(0));
    host_write(7, img[7], one_bit(38));
    host_write(11, img[11], one_bit(20));
    run_seq(n * 4, model_crc(n), 1'b0);
    check(outcome == 1, "R7 release after correction", 32'(outcome), 32'd1);
    check(corr_cnt == 3, "R7 correction count", 32'(corr_cnt), 32'd3);
    clear_status();
    run_seq(n * 4, model_crc(n), 1'b0);
    check(outcome == 1 && corr_cnt == 0, "R7 scrubbed memory", 32'(corr_cnt), 32'd0);

    // R8 CRC mismatch, interrupt mode
    clear_status();
    run_seq(n * 4, model_crc(n) ^ 32'h0000_0100, 1'b0);
    check(outcome == 2 && stat_stage == 2'd2, "R8 CRC stage", 32'(stat_stage), 32'd2);
    check(stat_addr == AW'(n - 1), "R8 CRC fail address", 32'(stat_addr), 32'(n - 1));

    // R11 R12: request and host write arriving mid-scan
    clear_status();
    n = 32;
    load_image(n);
    cfg_img_len = LEN_W'(n * 4); cfg_ref_crc = model_crc(n); cfg_fail_rst = 1'b0;
    wake(1'b1);
    repeat (4) @(negedge clk);
    wake(1'b1);
    host_write(n - 1, ~img[n - 1], '0);
    wait_done();
    check(outcome == 1, "R12 busy host write ignored", 32'(outcome), 32'd1);
    repeat (10) @(negedge clk);
    check(cc_rst_n, "R11 busy request ignored", 32'(cc_rst_n), 32'd1);
    run_seq(n * 4, model_crc(n), 1'b0);
    check(outcome == 1, "R12 memory intact", 32'(outcome), 32'd1);

    // boundaries: one word and the full memory
    clear_status();
    load_image(1);
    run_seq(4, model_crc(1), 1'b0);
    check(outcome == 1, "R2 single-word image", 32'(outcome), 32'd1);
    load_image(WORDS);
    c = model_crc(WORDS);
    run_seq(WORDS * 4, c, 1'b0);
    check(outcome == 1, "R3 full memory image", 32'(outcome), 32'd1);

    // random rounds
    for (int r = 0; r < 10; r++) begin
      clear_status();
      n = 1 + ($urandom % 48);
      load_image(n);
      k = $urandom % 4;
      if (k == 3) begin
        w1 = $urandom % n;
        b1 = $urandom % CW;
        b2 = (b1 + 1 + ($urandom % (CW - 1))) % CW;
        host_write(w1, img[w1], one_bit(b1) | one_bit(b2));
        run_seq(n * 4, model_crc(n), 1'b0);
        check(outcome == 2 && stat_stage == 2'd1 && stat_addr == AW'(w1),
              "R6 random double error", {22'd0, stat_stage, stat_addr},
              {22'd0, 2'd1, AW'(w1)});
      end else if (k == 2) begin
        run_seq(n * 4, model_crc(n) ^ (32'd1 << ($urandom % 32)), 1'b1);
        check(outcome == 3 && stat_stage == 2'd2 && stat_addr == AW'(n - 1),
              "R8 random CRC mismatch", {22'd0, stat_stage, stat_addr},
              {22'd0, 2'd2, AW'(n - 1)});
      end else begin
        w1 = $urandom % n;
        w2 = (w1 + 1) % n;
        host_write(w1, img[w1], one_bit($urandom % CW));
        if (k == 1 && n > 1) host_write(w2, img[w2], one_bit($urandom % CW));
        run_seq(n * 4, model_crc(n), 1'b0);
        check(outcome == 1, "R7 random correctable release", 32'(outcome), 32'd1);
        check(corr_cnt == ((k == 1 && n > 1) ? 2 : 1), "R7 random count",
              32'(corr_cnt), (k == 1 && n > 1) ? 32'd2 : 32'd1);
      end
    end

    summary();
    $finish;
  end
endmodule